// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns a per-oscillator-cycle enable (nominally 32768 per second) into a single-cycle one-second tick, and applies a signed digital rate trim. The trim works over a repeating window of 64 minutes. The calendar supplies a strobe at each minute boundary, which advances a minute index. If the index lies below twice the calibration magnitude, one second of that minute is altered. A positive trim shortens the second by a whole divide-by-256 stage. A negative trim lengthens it by half a stage. The step sizes are therefore asymmetric.

The block also drives the level of an open-drain test/output pin. With the test bit set, the pin carries a square wave from a free-running, uncalibrated divide-by-64 counter (512 Hz nominal). With the test bit clear, the pin follows the output-level bit. A stop input freezes both dividers, as a halted oscillator would. The register holding the calibration fields lives elsewhere. Its fields arrive here as plain inputs.

Top module: `rtcp_prescaler`

## Requirements
- R1: With no trim pending, each second lasts exactly OSC_HZ counted oscillator enables. This holds for any minute outside the trimmed range and for every minute when the magnitude is 0.
- R2: Only cycles with `osc_en` high advance the second divider. With the enable high every other clock, a nominal second spans 2*OSC_HZ clocks.
- R3: When `cal_fast` is 1 (positive trim, speeds the clock up), an affected second lasts OSC_HZ-POS_TRIM enables. The defaults are 32768-256.
- R4: When `cal_fast` is 0 (negative trim, slows the clock down), an affected second lasts OSC_HZ+NEG_TRIM enables. The defaults are 32768+128.
- R5: Each `minute_strobe` pulse advances a minute index that wraps from CYCLE_MIN-1 to 0. The minute entered is affected exactly when its index is below 2*`cal_mag`.
- R6: In an affected minute, only the second that starts at the first tick after the strobe is altered. The following second is nominal.
- R7: With `ft_en`=1 and `stop`=0, `pin_pull_low` toggles every TEST_DIV/2 counted enables. This is 4 clocks when TEST_DIV is 8 and the enable is always high. The rate does not depend on the calibration inputs.
- R8: With `ft_en`=0, `pin_pull_low` equals the inverse of `out_level`, one clock later. A level of 0 pulls the pin low and a level of 1 releases it.
- R9: While `stop`=1, no tick is produced and the test wave holds its level.
- R10: Reset clears the tick and releases the pin (`pin_pull_low`=0). It puts the minute index at 0 with no trim pending, so the first strobe enters minute 1.
- R11: `sec_tick` is high for exactly one clock per second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| stop | input | 1 | Halts both dividers while 1 |
| minute_strobe | input | 1 | Single-cycle pulse at each minute boundary |
| cal_mag | input | MAG_W | Calibration magnitude, binary 0..31 |
| cal_fast | input | 1 | Trim sign: 1 shortens, 0 lengthens |
| ft_en | input | 1 | Selects the test square wave for the pin |
| out_level | input | 1 | Pin level when the test wave is off |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |
| pin_pull_low | output | 1 | 1 pulls the open-drain pin low, 0 releases it |

## Verification
The bench sweeps the full 64-minute window for several magnitudes and both signs, and it measures the altered second after each strobe. An off-by-one in the minute comparison would show up at indices 2N-1 and 2N. A swapped sign or step size would give lengths of 132 and 120 where the opposite is expected. A wrap that failed to return to 0 would spoil the trim in minute 0 of the second pass. The bench also checks that the second after a trimmed one is nominal, that a halved enable doubles the period, and that the test wave keeps a fixed half-period while a trim is active. A design that let the trim leak into the test divider would show an irregular half-period. A design that ignored `stop` would tick during the freeze.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
   typedef enum logic [1:0] {
      TRIM_NONE = 2'd0,
      TRIM_FAST = 2'd1,
      TRIM_SLOW = 2'd2
   } trim_e;
endpackage

// File: rtl/rtcp_cal_seq.sv
module rtcp_cal_seq
   import rtcp_pkg::*;
#(
   parameter int CYCLE_MIN = 64,
   parameter int MAG_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             minute_strobe,
   input  logic [MAG_W-1:0] cal_mag,
   input  logic             cal_fast,
   input  logic             boundary,
   output trim_e            req_mode
);
   localparam int IDX_W = $clog2(CYCLE_MIN);
   localparam int CMP_W = IDX_W + MAG_W + 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CYCLE_MIN - 1);

   initial begin
      assert (CYCLE_MIN >= 2 * ((1 << MAG_W) - 1))
         else $error("window shorter than largest trimmed span");
      assert (CYCLE_MIN > 1) else $error("window too small");
   end

   logic [IDX_W-1:0] idx_q, idx_next;
   logic [CMP_W-1:0] idx_ext, lim;
   logic             pend_q;

   always_comb begin
      idx_next = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      idx_ext  = {{(CMP_W-IDX_W){1'b0}}, idx_next};
      lim      = {{(CMP_W-MAG_W-1){1'b0}}, cal_mag, 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (minute_strobe) begin
            idx_q  <= idx_next;
            pend_q <= (idx_ext < lim);
         end else if (boundary) begin
            pend_q <= 1'b0;
         end
      end
   end

   always_comb begin
      if (!pend_q)       req_mode = TRIM_NONE;
      else if (cal_fast) req_mode = TRIM_FAST;
      else               req_mode = TRIM_SLOW;
   end

   a_r5_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (minute_strobe && idx_q == LAST_IDX) |=> (idx_q == '0));
   a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!minute_strobe) |=> $stable(idx_q));
endmodule

// File: rtl/rtcp_sec_div.sv
module rtcp_sec_div
   import rtcp_pkg::*;
#(
   parameter int OSC_HZ   = 32768,
   parameter int POS_TRIM = 256,
   parameter int NEG_TRIM = 128
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  osc_en,
   input  logic  halt,
   input  trim_e req_mode,
   output logic  boundary,
   output logic  sec_tick
);
   localparam int DIV_W = $clog2(OSC_HZ + NEG_TRIM);
   localparam logic [DIV_W-1:0] T_NOM  = DIV_W'(OSC_HZ - 1);
   localparam logic [DIV_W-1:0] T_FAST = DIV_W'(OSC_HZ - 1 - POS_TRIM);
   localparam logic [DIV_W-1:0] T_SLOW = DIV_W'(OSC_HZ - 1 + NEG_TRIM);

   initial begin
      assert (POS_TRIM > 0 && POS_TRIM < OSC_HZ) else $error("bad positive step");
      assert (NEG_TRIM > 0) else $error("bad negative step");
   end

   logic [DIV_W-1:0] cnt_q, term;
   trim_e            cur_q;
   logic             step;

   always_comb begin
      unique case (cur_q)
         TRIM_FAST: term = T_FAST;
         TRIM_SLOW: term = T_SLOW;
         default:   term = T_NOM;
      endcase
      step     = osc_en && !halt;
      boundary = step && (cnt_q == term);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         cur_q    <= TRIM_NONE;
         sec_tick <= 1'b0;
      end else begin
         sec_tick <= boundary;
         if (boundary) begin
            cnt_q <= '0;
            cur_q <= req_mode;
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= T_SLOW);
   a_r11_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);
   a_r9_halt_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !sec_tick);
endmodule

// File: rtl/rtcp_test_out.sv
module rtcp_test_out #(
   parameter int TEST_DIV = 64,
   parameter bit PIN_REG  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   input  logic halt,
   input  logic ft_en,
   input  logic out_level,
   output logic pin_pull_low
);
   localparam int TW = $clog2(TEST_DIV);

   initial begin
      assert (TEST_DIV >= 2 && (1 << TW) == TEST_DIV)
         else $error("test divider must be a power of two");
   end

   logic [TW-1:0] tcnt_q;
   logic          pull_d;

   always_ff @(posedge clk) begin
      if (!rst_n)                tcnt_q <= '0;
      else if (osc_en && !halt)  tcnt_q <= tcnt_q + 1'b1;
   end

   assign pull_d = ft_en ? !tcnt_q[TW-1] : !out_level;

   generate
      if (PIN_REG) begin : g_reg
         logic pull_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pull_q <= 1'b0;
            else        pull_q <= pull_d;
         end
         assign pin_pull_low = pull_q;
         a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (!ft_en) |=> (pin_pull_low == !$past(out_level)));
      end else begin : g_comb
         assign pin_pull_low = rst_n && pull_d;
      end
   endgenerate

   a_r9_wave_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(tcnt_q));
endmodule

// File: rtl/rtcp_prescaler.sv
module rtcp_prescaler
   import rtcp_pkg::*;
#(
   parameter int OSC_HZ    = 32768,
   parameter int POS_TRIM  = 256,
   parameter int NEG_TRIM  = 128,
   parameter int TEST_DIV  = 64,
   parameter int CYCLE_MIN = 64,
   parameter int MAG_W     = 5,
   parameter bit PIN_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_en,
   input  logic             stop,
   input  logic             minute_strobe,
   input  logic [MAG_W-1:0] cal_mag,
   input  logic             cal_fast,
   input  logic             ft_en,
   input  logic             out_level,
   output logic             sec_tick,
   output logic             pin_pull_low
);
   trim_e req_mode;
   logic  boundary;

   rtcp_cal_seq #(.CYCLE_MIN(CYCLE_MIN), .MAG_W(MAG_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .minute_strobe(minute_strobe),
      .cal_mag(cal_mag), .cal_fast(cal_fast), .boundary(boundary),
      .req_mode(req_mode));

   rtcp_sec_div #(.OSC_HZ(OSC_HZ), .POS_TRIM(POS_TRIM), .NEG_TRIM(NEG_TRIM)) u_div (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(stop),
      .req_mode(req_mode), .boundary(boundary), .sec_tick(sec_tick));

   rtcp_test_out #(.TEST_DIV(TEST_DIV), .PIN_REG(PIN_REG)) u_tst (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(stop),
      .ft_en(ft_en), .out_level(out_level), .pin_pull_low(pin_pull_low));
endmodule

// File: tb/tb_rtcp_prescaler.sv
module tb_rtcp_prescaler;
   localparam int OSC = 128, POS = 8, NEG = 4, TDIV = 8, WIN = 64, MW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0, osc_en = 1'b1, stop = 1'b0, minute_strobe = 1'b0;
   logic [MW-1:0] cal_mag = '0;
   logic cal_fast = 1'b1, ft_en = 1'b0, out_level = 1'b1;
   logic sec_tick, pin_pull_low;
   logic half_en = 1'b0;
   int checks = 0, failures = 0, tb_idx = 0;

   always #4 clk = ~clk;

   always @(negedge clk) osc_en <= half_en ? ~osc_en : 1'b1;

   rtcp_prescaler #(.OSC_HZ(OSC), .POS_TRIM(POS), .NEG_TRIM(NEG), .TEST_DIV(TDIV),
                    .CYCLE_MIN(WIN), .MAG_W(MW)) dut (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
      .minute_strobe(minute_strobe), .cal_mag(cal_mag), .cal_fast(cal_fast),
      .ft_en(ft_en), .out_level(out_level), .sec_tick(sec_tick),
      .pin_pull_low(pin_pull_low));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_tick();
      do @(negedge clk); while (!sec_tick);
   endtask

   task automatic measure(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!sec_tick);
   endtask

   // strobe just after a tick, then measure the second that follows the next tick
   task automatic minute(input string req);
      int len, exp;
      minute_strobe = 1'b1;
      @(negedge clk);
      minute_strobe = 1'b0;
      tb_idx = (tb_idx + 1) % WIN;
      wait_tick();
      measure(len);
      if (tb_idx < 2 * int'(cal_mag)) exp = cal_fast ? OSC - POS : OSC + NEG;
      else exp = OSC;
      check(len == exp, req, len, exp);
   endtask

   task automatic sweep(input int mag, input bit fast, input int nmin, input string req);
      cal_mag = MW'(mag);
      cal_fast = fast;
      for (int m = 0; m < nmin; m++) minute(req);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int len, prev, gap, ticks;
      bit stable;
      cal_mag = 5'd1;
      cal_fast = 1'b1;
      repeat (4) @(negedge clk);
      // R10: outputs in reset
      check(sec_tick == 1'b0, "R10 tick in reset", sec_tick, 0);
      check(pin_pull_low == 1'b0, "R10 pin released in reset", pin_pull_low, 0);
      rst_n = 1'b1;
      wait_tick();
      // R11: tick is one cycle wide
      @(negedge clk);
      check(sec_tick == 1'b0, "R11 tick width", sec_tick, 0);
      wait_tick();
      measure(len);
      check(len == OSC, "R1 nominal after reset", len, OSC);
      // R6/R10: first strobe enters minute 1 (affected for N=1), next second nominal
      minute_strobe = 1'b1; @(negedge clk); minute_strobe = 1'b0;
      tb_idx = 1;
      wait_tick();
      measure(len);
      check(len == OSC - POS, "R10 R3 minute 1 trimmed", len, OSC - POS);
      measure(len);
      check(len == OSC, "R6 following second nominal", len, OSC);
      minute("R10 minute 2 untrimmed");
      // R2: halved enable doubles the period
      half_en = 1'b1;
      wait_tick();
      measure(len);
      check(len == 2 * OSC, "R2 half-rate enable", len, 2 * OSC);
      half_en = 1'b0;
      wait_tick();
      // R3/R5: full window including wrap to 0
      sweep(31, 1'b1, 65, "R3 R5 fast N=31");
      sweep(1, 1'b1, 64, "R5 fast N=1");
      sweep(3, 1'b0, 64, "R4 R5 slow N=3");
      sweep(31, 1'b0, 20, "R4 slow N=31");
      sweep(0, 1'b1, 8, "R1 magnitude zero");
      // R8: level follows out_level
      ft_en = 1'b0; out_level = 1'b0;
      @(negedge clk); @(negedge clk);
      check(pin_pull_low == 1'b1, "R8 level 0 pulls low", pin_pull_low, 1);
      out_level = 1'b1;
      @(negedge clk);
      check(pin_pull_low == 1'b0, "R8 level 1 releases", pin_pull_low, 0);
      // R7: test wave half-period, with a trim armed
      cal_mag = 5'd31; cal_fast = 1'b1;
      minute_strobe = 1'b1; @(negedge clk); minute_strobe = 1'b0;
      ft_en = 1'b1;
      repeat (3) @(negedge clk);
      prev = pin_pull_low;
      do begin @(negedge clk); end while (pin_pull_low == prev);
      for (int k = 0; k < 40; k++) begin
         prev = pin_pull_low;
         gap = 0;
         do begin @(negedge clk); gap++; end while (pin_pull_low == prev && gap < 50);
         check(gap == TDIV / 2, "R7 test half-period", gap, TDIV / 2);
      end
      // R9: stop freezes tick and wave
      stop = 1'b1;
      @(negedge clk); @(negedge clk);
      prev = pin_pull_low;
      ticks = 0; stable = 1'b1;
      for (int k = 0; k < 3 * OSC; k++) begin
         @(negedge clk);
         if (sec_tick) ticks++;
         if (pin_pull_low != prev) stable = 1'b0;
      end
      check(ticks == 0, "R9 no tick while stopped", ticks, 0);
      check(stable, "R9 wave held while stopped", stable, 1);
      stop = 1'b0;
      wait_tick();
      check(1'b1, "R9 resumes", 1, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule